// File: doc/BRIEF.md
# Read-Priority Age-Ordered Request Arbiter

This block decides which of several queued memory requests is sent to the memory device next. Each request slot presents a valid flag, a read/write type, an age stamp taken from a global sequence counter when the request was enqueued, a flag saying its timing rules are met, and, for writes, a flag saying its write data is ready. A slot is eligible only when all of its conditions hold.

Among the eligible slots, reads always win over writes. Within the winning type, the oldest request wins. Age stamps are compared with wraparound-safe subtraction, so the sequence counter may roll over freely. The result is registered and presented for one cycle as a one-hot grant, a binary slot index and a grant-valid flag. The requester drops its valid flag in the cycle after it sees the grant. While a grant is shown, the arbiter excludes the granted slot from its next decision, so the slot is not granted a second time while its valid flag is still falling.

A two-state controller drives the grant. The state ST_IDLE means no grant is shown, and ST_GRANT means a grant is shown. There are three transitions:
- IDLE_TO_GRANT is taken when a candidate exists.
- GRANT_TO_GRANT is taken when another candidate remains after the current grant is masked out.
- GRANT_TO_IDLE is taken when no candidate remains.

Top module: `rdpri_age_arbiter`

## Requirements
- R1: While reset is asserted, and after release until a slot becomes eligible, grant_vld is 0, grant_oh is all zeros and grant_idx is 0.
- R2: When exactly one slot is eligible in a cycle, that slot is granted on the very next clock edge, with no extra arbitration cycle.
- R3: When at least one eligible read exists, a read is granted, regardless of the age of any eligible write.
- R4: Among eligible reads, the oldest read is granted. When no read is eligible, the oldest eligible write is granted.
- R5: Stamp a is older than stamp b when the top bit of (a - b) mod 2^SEQ_W is 1. For example, 250 is older than 5 for an 8-bit sequence. Live stamps must lie within half the sequence range of each other.
- R6: When the best candidates carry equal stamps, the lowest slot index is granted.
- R7: A slot is eligible only if slot_valid and slot_timing_ok are both 1. A write (slot_is_rd = 0) additionally needs slot_wdata_rdy = 1. An ineligible slot never receives a grant, whatever its type or age.
- R8: When no slot is eligible, no grant is issued on the next edge.
- R9: grant_oh has at most one bit set. grant_vld is 1 exactly when a bit is set, and grant_idx gives the position of that bit.
- R10: Each grant lasts one cycle. The slot granted in a cycle is excluded from the decision made at the end of that cycle, so the same slot is never granted on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | NUM_SLOTS | Slot holds a request |
| slot_is_rd | input | NUM_SLOTS | 1 = read request, 0 = write request |
| slot_timing_ok | input | NUM_SLOTS | Slot's timing rules are satisfied |
| slot_wdata_rdy | input | NUM_SLOTS | Write data is ready (ignored for reads) |
| slot_age | input | NUM_SLOTS*SEQ_W | Packed age stamps, slot i in bits [i*SEQ_W +: SEQ_W] |
| grant_oh | output | NUM_SLOTS | One-hot grant, registered |
| grant_idx | output | IDX_W | Binary index of the granted slot |
| grant_vld | output | 1 | A grant is being issued this cycle |

## Verification
The hardest situation to reach is a correct ordering decision made just after the stamp counter has wrapped. In that case an old write, held back because its data is not ready, sits next to younger reads whose stamps have rolled past zero, while the slot granted in the previous cycle still shows its valid flag.

Directed cases build each of these conditions on purpose: wrapped stamps, equal stamps, ready and not-ready writes, and a slot that holds its valid flag across a grant. A long random phase then refills freed slots from a running sequence counter that rolls over several times. In that phase, timing and write-ready flags are random, and the outputs are compared against a behavioural model on every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/arb_elig_mask.sv
module arb_elig_mask #(
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0] slot_valid,
    input  logic [NUM_SLOTS-1:0] slot_is_rd,
    input  logic [NUM_SLOTS-1:0] slot_timing_ok,
    input  logic [NUM_SLOTS-1:0] slot_wdata_rdy,
    input  logic [NUM_SLOTS-1:0] block_mask,
    output logic [NUM_SLOTS-1:0] cand
);
    logic [NUM_SLOTS-1:0] base_ok;
    logic [NUM_SLOTS-1:0] rd_ok;
    logic [NUM_SLOTS-1:0] wr_ok;

    always_comb begin
        base_ok = slot_valid & slot_timing_ok & ~block_mask;
        rd_ok   = base_ok & slot_is_rd;
        wr_ok   = base_ok & ~slot_is_rd & slot_wdata_rdy;
        // reads shadow all writes whenever any read is eligible
        cand    = (rd_ok != '0) ? rd_ok : wr_ok;
    end

endmodule

// File: rtl/arb_age_pick.sv
module arb_age_pick #(
    parameter int NUM_SLOTS = 8,
    parameter int SEQ_W     = 8
) (
    input  logic [NUM_SLOTS-1:0]       cand,
    input  logic [NUM_SLOTS*SEQ_W-1:0] slot_age,
    output logic [NUM_SLOTS-1:0]       win_oh
);
    logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] beats;
    logic [NUM_SLOTS-1:0]                raw_win;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
        for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_col
            if (i == j) begin : g_self
                assign beats[i][j] = 1'b1;
            end else begin : g_pair
                logic [SEQ_W-1:0] diff;
                logic             same;
                assign diff = slot_age[i*SEQ_W +: SEQ_W] - slot_age[j*SEQ_W +: SEQ_W];
                assign same = (diff == '0);
                // i beats j: j absent, i strictly older, or equal and i lower
                assign beats[i][j] = ~cand[j] | diff[SEQ_W-1] | (same & (i < j));
            end
        end
        assign raw_win[i] = cand[i] & (&beats[i]);
    end

    // keep the result one-hot even if stamps leave the valid window
    assign win_oh = raw_win & (~raw_win + 1'b1);

endmodule

// File: rtl/arb_oh_encode.sv
module arb_oh_encode #(
    parameter int NUM_SLOTS = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_SLOTS-1:0] oh,
    output logic [IDX_W-1:0]     idx,
    output logic                 any
);
    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (oh[k]) idx = idx | IDX_W'(k);
        end
        any = (oh != '0);
    end

endmodule

// File: rtl/rdpri_age_arbiter.sv
module rdpri_age_arbiter
    import arb_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    parameter  int SEQ_W     = 8,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       slot_valid,
    input  logic [NUM_SLOTS-1:0]       slot_is_rd,
    input  logic [NUM_SLOTS-1:0]       slot_timing_ok,
    input  logic [NUM_SLOTS-1:0]       slot_wdata_rdy,
    input  logic [NUM_SLOTS*SEQ_W-1:0] slot_age,
    output logic [NUM_SLOTS-1:0]       grant_oh,
    output logic [IDX_W-1:0]           grant_idx,
    output logic                       grant_vld
);
    arb_state_e           state_q;
    arb_state_e           state_d;
    logic [NUM_SLOTS-1:0] grant_oh_q;
    logic [IDX_W-1:0]     grant_idx_q;
    logic [NUM_SLOTS-1:0] block_mask;
    logic [NUM_SLOTS-1:0] cand;
    logic [NUM_SLOTS-1:0] win_oh;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_any;

    // the slot shown as granted is still valid this cycle; keep it out
    assign block_mask = (state_q == ST_GRANT) ? grant_oh_q : '0;

    arb_elig_mask #(.NUM_SLOTS(NUM_SLOTS)) u_elig (
        .slot_valid     (slot_valid),
        .slot_is_rd     (slot_is_rd),
        .slot_timing_ok (slot_timing_ok),
        .slot_wdata_rdy (slot_wdata_rdy),
        .block_mask     (block_mask),
        .cand           (cand)
    );

    arb_age_pick #(.NUM_SLOTS(NUM_SLOTS), .SEQ_W(SEQ_W)) u_pick (
        .cand     (cand),
        .slot_age (slot_age),
        .win_oh   (win_oh)
    );

    arb_oh_encode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_enc (
        .oh  (win_oh),
        .idx (win_idx),
        .any (win_any)
    );

    // next-state decision
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = win_any ? ST_GRANT : ST_IDLE;   // IDLE_TO_GRANT
            ST_GRANT: state_d = win_any ? ST_GRANT : ST_IDLE;   // GRANT_TO_GRANT / GRANT_TO_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered grant outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_oh_q  <= '0;
            grant_idx_q <= '0;
        end else if (state_d == ST_GRANT) begin
            grant_oh_q  <= win_oh;
            grant_idx_q <= win_idx;
        end else begin
            grant_oh_q  <= '0;
            grant_idx_q <= '0;
        end
    end

    assign grant_oh  = grant_oh_q;
    assign grant_idx = grant_idx_q;
    assign grant_vld = (state_q == ST_GRANT);

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter  int NUM_SLOTS = 8,
    parameter  int SEQ_W     = 8,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLOTS-1:0]       slot_valid,
    input logic [NUM_SLOTS-1:0]       slot_is_rd,
    input logic [NUM_SLOTS-1:0]       slot_timing_ok,
    input logic [NUM_SLOTS-1:0]       slot_wdata_rdy,
    input logic [NUM_SLOTS*SEQ_W-1:0] slot_age,
    input logic [NUM_SLOTS-1:0]       grant_oh,
    input logic [IDX_W-1:0]           grant_idx,
    input logic                       grant_vld
);
    logic [NUM_SLOTS-1:0] elig;
    logic [SEQ_W-1:0]     age_fold;

    assign elig = slot_valid & slot_timing_ok & (slot_is_rd | slot_wdata_rdy);

    always_comb begin
        age_fold = '0;
        for (int k = 0; k < NUM_SLOTS; k++) age_fold = age_fold ^ slot_age[k*SEQ_W +: SEQ_W];
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!grant_vld && grant_oh == '0 && grant_idx == '0)); // R1

    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (grant_vld == ($past(elig & ~grant_oh) != '0))); // R2

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && ((grant_oh & $past(slot_is_rd)) == '0))
            |-> ($past(elig & slot_is_rd & ~grant_oh) == '0)); // R3

    AST_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ((grant_oh & $past(elig)) != '0)); // R7

    AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh) && (grant_vld == (grant_oh != '0))); // R9

    AST_IDX_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> grant_oh[grant_idx]); // R9

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |=> ((grant_oh & $past(grant_oh)) == '0)); // R10

    AST_AGES_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> !$isunknown(age_fold)); // R5

endmodule

bind rdpri_age_arbiter arb_checker #(.NUM_SLOTS(NUM_SLOTS), .SEQ_W(SEQ_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_valid     (slot_valid),
    .slot_is_rd     (slot_is_rd),
    .slot_timing_ok (slot_timing_ok),
    .slot_wdata_rdy (slot_wdata_rdy),
    .slot_age       (slot_age),
    .grant_oh       (grant_oh),
    .grant_idx      (grant_idx),
    .grant_vld      (grant_vld)
);

// File: tb/sim_rdpri_age_arbiter.sv
`timescale 1ns/1ps
module sim_rdpri_age_arbiter;
    localparam int N = 8;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b1;
    logic [N-1:0]   slot_valid, slot_is_rd, slot_timing_ok, slot_wdata_rdy;
    logic [N*W-1:0] slot_age;
    logic [N-1:0]   grant_oh;
    logic [2:0]     grant_idx;
    logic           grant_vld;

    bit       sv [N];
    bit       srd[N];
    bit       stm[N];
    bit       swr[N];
    bit [7:0] sage[N];

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rdpri_age_arbiter #(.NUM_SLOTS(N), .SEQ_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .slot_valid(slot_valid), .slot_is_rd(slot_is_rd),
        .slot_timing_ok(slot_timing_ok), .slot_wdata_rdy(slot_wdata_rdy),
        .slot_age(slot_age),
        .grant_oh(grant_oh), .grant_idx(grant_idx), .grant_vld(grant_vld)
    );

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            slot_valid[i]     = sv[i];
            slot_is_rd[i]     = srd[i];
            slot_timing_ok[i] = stm[i];
            slot_wdata_rdy[i] = swr[i];
            slot_age[i*W +: W] = sage[i];
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            sv[i] = 0; srd[i] = 0; stm[i] = 0; swr[i] = 0; sage[i] = '0;
        end
        drive();
    endtask

    task automatic put(int s, bit rd, bit tm, bit wr, int age);
        sv[s] = 1; srd[s] = rd; stm[s] = tm; swr[s] = wr; sage[s] = 8'(age);
    endtask

    task automatic step();
        drive();
        @(posedge clk);
        @(negedge clk);
    endtask

    // want < 0 means no grant expected
    task automatic chk_grant(int want, string tag);
        logic [N-1:0] exp_oh;
        int act;
        exp_oh = (want >= 0) ? N'(1 << want) : '0;
        act = grant_vld ? int'(grant_idx) : -1;
        n_tests++;
        if (grant_vld !== (want >= 0) || grant_oh !== exp_oh || (want >= 0 && act != want)) begin
            n_fail++;
            $display("FAIL %s: actual vld=%0b oh=%b idx=%0d, expected vld=%0b oh=%b idx=%0d",
                     tag, grant_vld, grant_oh, act, (want >= 0), exp_oh, want);
        end
    endtask

    // behavioural reference: returns chosen slot or -1
    function automatic int model_pick(int masked);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            bit ok;
            ok = sv[i] && stm[i] && (srd[i] || swr[i]) && (i != masked);
            if (ok) begin
                if (best < 0) best = i;
                else if (srd[i] && !srd[best]) best = i;
                else if (srd[i] == srd[best]) begin
                    logic signed [7:0] d;
                    d = signed'(sage[i] - sage[best]);
                    if (d < 0) best = i;
                end
            end
        end
        return best;
    endfunction

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int exp_idx;
        int seq;
        clear_all();
        #5 rst_n = 1'b0;
        @(negedge clk);
        put(3, 1, 1, 0, 7);
        drive();
        @(posedge clk); @(negedge clk);
        chk_grant(-1, "R1 in reset");
        clear_all();
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk_grant(-1, "R1 after release");

        // R2 single eligible write
        put(5, 0, 1, 1, 12); step();
        chk_grant(5, "R2 single");
        clear_all(); step(); step();

        // R3 read beats older write
        put(1, 0, 1, 1, 10); put(2, 1, 1, 0, 40); step();
        chk_grant(2, "R3 read first");
        clear_all(); step(); step();

        // R4 oldest read
        put(3, 1, 1, 0, 20); put(6, 1, 1, 0, 15); step();
        chk_grant(6, "R4 oldest read");
        clear_all(); step(); step();

        // R4 oldest write
        put(0, 0, 1, 1, 9); put(4, 0, 1, 1, 7); step();
        chk_grant(4, "R4 oldest write");
        clear_all(); step(); step();

        // R5 wraparound
        put(0, 1, 1, 0, 5); put(7, 1, 1, 0, 250); step();
        chk_grant(7, "R5 wrap");
        clear_all(); step(); step();

        // R6 equal stamps
        put(4, 1, 1, 0, 33); put(1, 1, 1, 0, 33); step();
        chk_grant(1, "R6 tie");
        clear_all(); step(); step();

        // R7 timing gate on a read
        put(3, 1, 0, 0, 1); put(5, 0, 1, 1, 90); step();
        chk_grant(5, "R7 timing");
        clear_all(); step(); step();

        // R7 write without data, only candidate
        put(2, 0, 1, 0, 3); step();
        chk_grant(-1, "R7 wdata");
        clear_all(); step(); step();

        // R8 nothing valid
        step();
        chk_grant(-1, "R8 idle");

        // R10 slots keep valid across grants
        put(2, 1, 1, 0, 1); put(5, 1, 1, 0, 2); step();
        chk_grant(2, "R10 first");
        step();
        chk_grant(5, "R10 masked");
        step();
        chk_grant(2, "R10 alternate");
        clear_all(); step(); step();

        // random phase against model, compared each cycle
        exp_idx = -1;
        seq = 200;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int spread = 0;
            chk_grant(exp_idx, "R2 R3 R4 R5 R6 R7 R8 R9 R10 model");
            if (exp_idx >= 0) sv[exp_idx] = 0;
            for (int i = 0; i < N; i++) begin
                int d;
                d = int'(8'(seq - sage[i]));
                if (sv[i] && d > spread) spread = d;
            end
            for (int i = 0; i < N; i++) begin
                if (!sv[i] && ($urandom % 3 == 0) && spread < 100) begin
                    sv[i] = 1; srd[i] = 1'($urandom); sage[i] = 8'(seq);
                    seq = seq + 1;
                end
                stm[i] = ($urandom % 4) != 0;
                swr[i] = ($urandom % 4) != 0;
            end
            drive();
            exp_idx = model_pick(exp_idx);
            @(posedge clk);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule